// File: doc/BRIEF.md
# Byte-Lane Steering Unit with Misaligned Word Split

This block sits between a processor-side access port and a 16-bit external bus built from two byte-wide banks. The even bank sits on the low data lanes and the odd bank on the high data lanes. For each access it produces a word address, an address bit zero (`bus_a0`, low enables the even bank) and an active-low high-bank enable (`bus_bhe_n`, low enables the odd bank). It also places write bytes on the lanes of the enabled bank and collects read bytes from them.

A byte access, or a word access at an even address, takes one bus cycle. A word at an odd address spans both banks and two word addresses, so the block splits it into two bus cycles in a fixed order. The first cycle goes to the odd bank at the starting word address. The second goes to the even bank at the next word address. For a read, the two returned bytes are joined into one word. Each bus cycle goes to an external bus sequencer through a `bus_req`/`bus_done` handshake. The processor side sees a single `cpu_done` pulse per access.

The processor raises `cpu_req` for one cycle, either while the block is idle or in the cycle where `cpu_done` is high. The request fields must be valid in that cycle.

Top module: `lane_split_unit`

## Requirements
- R1: A byte read at an even address makes one bus cycle with `bus_a0`=0 and `bus_bhe_n`=1. `cpu_rdata` is then `{8'h00, bus_rdata[7:0]}`.
- R2: A byte read at an odd address makes one bus cycle with `bus_a0`=1 and `bus_bhe_n`=0. `cpu_rdata` is then `{8'h00, bus_rdata[15:8]}`.
- R3: A byte write places `cpu_wdata[7:0]` on the lanes of the enabled bank: bits 7:0 for an even address, bits 15:8 for an odd address.
- R4: A word access at an even address makes one bus cycle with `bus_a0`=0 and `bus_bhe_n`=0. Write data goes on all 16 lanes unchanged, and read data comes back unchanged.
- R5: A word access at an odd address makes exactly two bus cycles.
  - The first has `bus_a0`=1, `bus_bhe_n`=0 and `bus_waddr` = `cpu_addr` >> 1.
  - The second has `bus_a0`=0, `bus_bhe_n`=1 and `bus_waddr` one higher.
- R6: For a misaligned word read, bits 15:8 returned in the first cycle become `cpu_rdata[7:0]`. Bits 7:0 returned in the second cycle become `cpu_rdata[15:8]`.
- R7: For a misaligned word write, `cpu_wdata[7:0]` is driven on lanes 15:8 in the first cycle, and `cpu_wdata[15:8]` on lanes 7:0 in the second.
- R8: `bus_req` stays high until `bus_done` is seen. The word address and bank enables stay stable while it waits.
- R9: `cpu_done` is a one-cycle pulse in the cycle after the `bus_done` of the final bus cycle. It never follows the first half of a split access.
- R10: The second-cycle word address wraps modulo 2^(AW-1) at the top of the address space.
- R11: A request raised in the same cycle as `cpu_done` is accepted, and its first bus cycle starts in the next cycle.
- R12: After reset, `bus_req` and `cpu_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-cycle access request |
| cpu_word | input | 1 | 1 = word access, 0 = byte access |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | 16 | Write data; a byte uses bits 7:0 |
| cpu_done | output | 1 | Access-complete pulse |
| cpu_rdata | output | 16 | Read result, valid with `cpu_done` |
| bus_req | output | 1 | Bus cycle request to the sequencer |
| bus_done | input | 1 | Bus cycle complete |
| bus_wr | output | 1 | Direction of the current bus cycle |
| bus_waddr | output | AW-1 | Word address |
| bus_a0 | output | 1 | Address bit zero; low enables the even bank |
| bus_bhe_n | output | 1 | Active-low odd-bank enable |
| bus_wdata | output | 16 | Write data lanes |
| bus_rdata | input | 16 | Read data lanes |

## Verification
Two events can coincide in one cycle.

The first pair is the `bus_done` that ends the first half of a split word and the presentation of the second half's address, enables and lanes. The sequencer model answers with zero wait states, so `bus_done` stays high across both halves. The per-cycle log of enables, address and write lanes then shows whether the second half was issued with the right values and counted as a separate cycle.

The second pair is `cpu_done` and the acceptance of a new request. A fresh request is raised exactly in the `cpu_done` cycle. The check is that its first bus cycle appears with the new address one cycle later, and that its read result is correct.

// File: rtl/lane_split_unit.sv
module lane_split_unit #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_word,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [15:0]   cpu_wdata,
  output logic          cpu_done,
  output logic [15:0]   cpu_rdata,
  output logic          bus_req,
  input  logic          bus_done,
  output logic          bus_wr,
  output logic [AW-2:0] bus_waddr,
  output logic          bus_a0,
  output logic          bus_bhe_n,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata
);
  localparam int WA = AW - 1;

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} st_t;

  st_t           st;
  logic          lat_word, lat_wr;
  logic [AW-1:0] lat_addr;
  logic [15:0]   lat_wdata;
  logic [7:0]    lo_keep;
  logic          done_q;
  logic [15:0]   rdata_q;

  wire odd    = lat_addr[0];
  wire split  = lat_word & odd;
  wire second = (st == S_SECOND);
  wire [7:0] lo_b = lat_wdata[7:0];
  wire [7:0] hi_b = lat_wdata[15:8];

  assign bus_req   = (st != S_IDLE);
  assign bus_wr    = lat_wr;
  assign bus_waddr = lat_addr[AW-1:1] + {{(WA-1){1'b0}}, second};
  assign bus_a0    = second ? 1'b0 : odd;
  assign bus_bhe_n = second ? 1'b1 : ~(lat_word | odd);
  assign bus_wdata = second ? {hi_b, hi_b} :
                     (lat_word && !odd) ? lat_wdata : {lo_b, lo_b};
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lat_word  <= 1'b0;
      lat_wr    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lo_keep   <= '0;
      done_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (cpu_req) begin
          lat_word  <= cpu_word;
          lat_wr    <= cpu_wr;
          lat_addr  <= cpu_addr;
          lat_wdata <= cpu_wdata;
          st        <= S_FIRST;
        end
        S_FIRST: if (bus_done) begin
          if (split) begin
            lo_keep <= bus_rdata[15:8];
            st      <= S_SECOND;
          end else begin
            rdata_q <= lat_word ? bus_rdata
                     : {8'h00, odd ? bus_rdata[15:8] : bus_rdata[7:0]};
            done_q  <= 1'b1;
            st      <= S_IDLE;
          end
        end
        S_SECOND: if (bus_done) begin
          rdata_q <= {bus_rdata[7:0], lo_keep};
          done_q  <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_waddr) &&
                                $stable(bus_a0) && $stable(bus_bhe_n)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  // R9
  done_after_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> $past(bus_done));

  // R5
  split_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done && lat_word && bus_a0) |=>
      (bus_req && !bus_a0 && bus_bhe_n));

  // R5
  bank_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !(bus_a0 && bus_bhe_n));

  // R11
  start_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(cpu_req));
endmodule

// File: tb/lane_split_unit_tb.sv
module lane_split_unit_tb;
  localparam int AW    = 20;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_word = 1'b0, cpu_wr = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic cpu_done;
  logic [15:0] cpu_rdata;
  logic bus_req, bus_done = 1'b0, bus_wr, bus_a0, bus_bhe_n;
  logic [AW-2:0] bus_waddr;
  logic [15:0] bus_wdata, bus_rdata = '0;

  lane_split_unit #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_word(cpu_word),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
    .bus_done(bus_done), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_a0(bus_a0), .bus_bhe_n(bus_bhe_n), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata));

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] mem [0:255];
  int wait_n = 0, cnt = 0, lg_n = 0;
  logic          lg_a0 [0:7];
  logic          lg_bhe [0:7];
  logic [AW-2:0] lg_wa [0:7];
  logic [15:0]   lg_wd [0:7];
  time last_done_t = 0;
  logic [15:0] got;

  // Bus sequencer model: answers after wait_n extra cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bus_req) begin
        if (cnt == wait_n) begin
          logic [7:0] ix;
          ix = {bus_waddr[6:0], 1'b0};
          bus_done  = 1'b1;
          bus_rdata = {bus_bhe_n ? 8'hEE : mem[ix+8'd1], bus_a0 ? 8'hEE : mem[ix]};
          if (bus_wr) begin
            if (!bus_a0)    mem[ix]      = bus_wdata[7:0];
            if (!bus_bhe_n) mem[ix+8'd1] = bus_wdata[15:8];
          end
          if (lg_n < 8) begin
            lg_a0[lg_n] = bus_a0; lg_bhe[lg_n] = bus_bhe_n;
            lg_wa[lg_n] = bus_waddr; lg_wd[lg_n] = bus_wdata;
          end
          lg_n = lg_n + 1;
          last_done_t = $time;
          cnt = 0;
        end else begin
          bus_done = 1'b0;
          cnt = cnt + 1;
        end
      end else begin
        bus_done = 1'b0;
        cnt = 0;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(bit w, bit wr, logic [AW-1:0] a, logic [15:0] d, int waits);
    wait_n = waits; lg_n = 0;
    cpu_word = w; cpu_wr = wr; cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic finish_access(int ncyc, string tag);
    int guard = 0;
    while (!cpu_done && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check({tag, " R9 done seen"}, {31'd0, cpu_done}, 32'd1);
    check({tag, " R9 bus cycle count"}, lg_n, ncyc);
    check({tag, " R9 done one cycle after last bus_done"},
          32'($time - last_done_t), CLK_P);
    got = cpu_rdata;
  endtask

  task automatic t_reset();
    check("R12 bus_req after reset", {31'd0, bus_req}, 32'd0);
    check("R12 cpu_done after reset", {31'd0, cpu_done}, 32'd0);
  endtask

  task automatic t_byte_even_rd();
    issue(1'b0, 1'b0, 20'h00040, 16'h0, 0);
    finish_access(1, "R1");
    check("R1 a0", {31'd0, lg_a0[0]}, 32'd0);
    check("R1 bhe_n", {31'd0, lg_bhe[0]}, 32'd1);
    check("R1 rdata", got, {8'h00, mem[8'h40]});
    @(negedge clk);
    check("R9 done pulse width", {31'd0, cpu_done}, 32'd0);
  endtask

  task automatic t_byte_odd_rd();
    issue(1'b0, 1'b0, 20'h00043, 16'h0, 2);
    finish_access(1, "R2");
    check("R2 a0", {31'd0, lg_a0[0]}, 32'd1);
    check("R2 bhe_n", {31'd0, lg_bhe[0]}, 32'd0);
    check("R2 waddr", lg_wa[0], 32'h21);
    check("R2 rdata", got, {8'h00, mem[8'h43]});
  endtask

  task automatic t_byte_wr();
    issue(1'b0, 1'b1, 20'h00051, 16'h77A5, 0);
    finish_access(1, "R3 odd");
    check("R3 odd lane", lg_wd[0][15:8], 32'hA5);
    check("R3 odd mem", mem[8'h51], 32'hA5);
    check("R3 even untouched", mem[8'h50], 32'h50 ^ 32'h5A);
    issue(1'b0, 1'b1, 20'h00060, 16'h773C, 1);
    finish_access(1, "R3 even");
    check("R3 even lane", lg_wd[0][7:0], 32'h3C);
    check("R3 even mem", mem[8'h60], 32'h3C);
  endtask

  task automatic t_word_even();
    issue(1'b1, 1'b1, 20'h00070, 16'hBEEF, 0);
    finish_access(1, "R4 wr");
    check("R4 a0", {31'd0, lg_a0[0]}, 32'd0);
    check("R4 bhe_n", {31'd0, lg_bhe[0]}, 32'd0);
    check("R4 lanes", lg_wd[0], 32'hBEEF);
    issue(1'b1, 1'b0, 20'h00070, 16'h0, 1);
    finish_access(1, "R4 rd");
    check("R4 rdata", got, 32'hBEEF);
  endtask

  task automatic t_word_odd_rd(int waits);
    issue(1'b1, 1'b0, 20'h00035, 16'h0, waits);
    finish_access(2, "R5");
    check("R5 first a0", {31'd0, lg_a0[0]}, 32'd1);
    check("R5 first bhe_n", {31'd0, lg_bhe[0]}, 32'd0);
    check("R5 first waddr", lg_wa[0], 32'h1A);
    check("R5 second a0", {31'd0, lg_a0[1]}, 32'd0);
    check("R5 second bhe_n", {31'd0, lg_bhe[1]}, 32'd1);
    check("R5 second waddr", lg_wa[1], 32'h1B);
    check("R6 reassembled", got, {mem[8'h36], mem[8'h35]});
  endtask

  task automatic t_word_odd_wr();
    issue(1'b1, 1'b1, 20'h00021, 16'h1234, 0);
    finish_access(2, "R7");
    check("R7 first lane", lg_wd[0][15:8], 32'h34);
    check("R7 second lane", lg_wd[1][7:0], 32'h12);
    check("R7 mem low byte", mem[8'h21], 32'h34);
    check("R7 mem high byte", mem[8'h22], 32'h12);
    check("R7 neighbour kept", mem[8'h20], 32'h20 ^ 32'h5A);
  endtask

  task automatic t_wrap();
    issue(1'b1, 1'b0, 20'hFFFFF, 16'h0, 0);
    finish_access(2, "R10");
    check("R10 first waddr", lg_wa[0], 32'h7FFFF);
    check("R10 second waddr wraps", lg_wa[1], 32'h0);
    check("R10 rdata", got, {mem[8'h00], mem[8'hFF]});
  endtask

  task automatic t_back_to_back();
    issue(1'b1, 1'b0, 20'h00011, 16'h0, 0);
    finish_access(2, "R11 first");
    check("R11 first rdata", got, {mem[8'h12], mem[8'h11]});
    // raise the next request in the cpu_done cycle
    issue(1'b0, 1'b0, 20'h00080, 16'h0, 0);
    check("R11 accepted next cycle", {31'd0, bus_req}, 32'd1);
    check("R11 new waddr", bus_waddr, 32'h40);
    finish_access(1, "R11 second");
    check("R11 second rdata", got, {8'h00, mem[8'h80]});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_byte_even_rd();
    t_byte_odd_rd();
    t_byte_wr();
    t_word_even();
    t_word_odd_rd(0);
    t_word_odd_rd(3);
    t_word_odd_wr();
    t_wrap();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule